// File: doc/BRIEF.md
# Serial Port Register Bank with Divisor Latch

This block is the byte-wide register interface of a classic asynchronous serial controller. A host reaches it through a plain bus with a 3-bit address, 8-bit write and read data, and separate read and write strobes. Behind the bank sit a transmit queue and a receive queue. The serializer, deserializer and baud tick generator lie outside the block. The bank drives their settings: the 16-bit baud divisor, the character format bits, the queue mode and the request-to-send line. It reports their state back to the host.

Offsets 0 and 1 have two meanings. Bit 7 of the line settings register is the divisor access bit. While it is clear, offset 0 is the data port: a write queues a byte for transmission, and a read takes the oldest received byte. While it is set, offsets 0 and 1 read and write the low and high divisor bytes, and the queues are left alone. Offset 2 (write only) selects the queue mode. Offset 3 holds the line settings, offset 4 the modem outputs, offset 5 the line status and offset 6 the modem inputs.

A small state machine holds the queue mode. It has three states. QM_OFF holds a single byte per direction and is the reset state. QM_STD uses 16-entry queues. QM_EXT uses queues of EXT_DEPTH entries. A write to offset 2 picks the next state from the value written. Bit 0 clear goes to QM_OFF. Bit 0 set with bit 5 clear goes to QM_STD. Bit 0 and bit 5 both set go to QM_EXT. Every transition that changes the state empties both queues. A write that selects the current state is a self-loop and keeps the queue contents. Software therefore writes 0x00 and then the enable value to reset and re-enable the queues.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line settings read 0x00, the divisor is 0x0000, modem control reads 0x00 with `rts_out` low, both queues are off, and line status reads 0x60 while `tx_shift_busy` is low.
- R2: With line settings bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 the high byte, and `divisor` equals {high, low}. These accesses neither add to the transmit queue nor remove from the receive queue.
- R3: All 8 bits of line settings (offset 3) read back as written, and `line_cfg` equals bits 5:0.
- R4: Transmit queue capacity is 1 with offset 2 bit 0 clear, 16 with bit 0 set and bit 5 clear, and EXT_DEPTH with both bits set. `fifo_on` shows bit 0 and `fifo_big` shows the extended mode. A data write to a full queue is dropped, and the bytes already queued stay unchanged.
- R5: A write to offset 2 that changes the queue mode empties both queues in that cycle. A write that keeps the mode keeps their contents.
- R6: Line status bit 0 is set while the receive queue holds data. Reads of offset 0 with bit 7 clear return received bytes oldest first, and bit 0 clears once the last byte is read. The read returns 0x00 when the queue is empty.
- R7: Line status bit 5 is set when the transmit queue is empty. Bit 6 is set when the queue is empty and `tx_shift_busy` is low.
- R8: Modem control (offset 4) reads back as written, and bit 1 drives `rts_out`.
- R9: Modem status (offset 6) reads `cts_in` in bit 4 and `dsr_in` in bit 5, with all other bits 0.
- R10: Reads of offset 2, offset 7, and offset 1 with bit 7 clear return 0x00. Writes to offsets 5, 6 and 7 have no effect.
- R11: A `rx_put` when the receive queue is at its mode capacity is dropped, and the bytes already received are kept.
- R12: `tx_ready` is high while the transmit queue is non-empty, and `tx_data` shows the oldest byte. `tx_take` removes that byte at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (read side effect at the clock edge) |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, combinational from address |
| divisor | output | 16 | Baud divisor to the tick generator |
| line_cfg | output | 6 | Data bits, parity and stop bit settings |
| fifo_on | output | 1 | Queues enabled |
| fifo_big | output | 1 | Extended queue depth selected |
| rts_out | output | 1 | Request-to-send |
| cts_in | input | 1 | Clear-to-send from the line |
| dsr_in | input | 1 | Data-set-ready from the line |
| tx_data | output | 8 | Oldest byte waiting for transmission |
| tx_ready | output | 1 | Transmit queue non-empty |
| tx_take | input | 1 | Serializer takes `tx_data` |
| tx_shift_busy | input | 1 | Serializer is still shifting a character |
| rx_data | input | 8 | Received byte from the deserializer |
| rx_put | input | 1 | Push `rx_data` into the receive queue |

## Verification
A wrong queue-mode state shows up at the ports in the cycle after the write to offset 2. `fifo_on` and `fifo_big` change at that point. A wrong state also moves the point at which data writes start to be dropped: the wrong capacity appears as a missing byte or an extra byte when the queue is drained through `tx_take`. A stale divisor access bit shows on the next access to offset 0. The access either moves `divisor` or reaches the queues, and `tx_ready` or line status bit 0 changes one edge later. Broken pointers or counts give out-of-order or repeated bytes on `tx_data` and on the bus reads.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    typedef enum logic [1:0] {
        QM_OFF = 2'd0,
        QM_STD = 2'd1,
        QM_EXT = 2'd2
    } qmode_e;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_DIVHI = 3'd1;
    localparam logic [2:0] OFS_QCTL  = 3'd2;
    localparam logic [2:0] OFS_LINE  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;

    localparam int QCTL_EN_BIT  = 0;
    localparam int QCTL_EXT_BIT = 5;
    localparam int LINE_DIV_BIT = 7;
    localparam int MCTL_RTS_BIT = 1;

    localparam int STD_DEPTH = 16;

endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] cap,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q >= cap);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/uart_rb_qmode.sv
module uart_rb_qmode
    import uart_rb_pkg::*;
#(
    parameter int EXT_DEPTH = 64,
    localparam int CW       = $clog2(EXT_DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_val,
    output logic          q_on,
    output logic          q_big,
    output logic          q_flush,
    output logic [CW-1:0] q_cap
);

    qmode_e state_q;
    qmode_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QM_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        if (ctl_we) begin
            if (!ctl_val[QCTL_EN_BIT]) begin
                state_d = QM_OFF;
            end else if (ctl_val[QCTL_EXT_BIT]) begin
                state_d = QM_EXT;
            end else begin
                state_d = QM_STD;
            end
        end
        q_flush = ctl_we && (state_d != state_q);

        unique case (state_q)
            QM_STD: begin
                q_on  = 1'b1;
                q_big = 1'b0;
                q_cap = CW'(STD_DEPTH);
            end
            QM_EXT: begin
                q_on  = 1'b1;
                q_big = 1'b1;
                q_cap = CW'(EXT_DEPTH);
            end
            default: begin
                q_on  = 1'b0;
                q_big = 1'b0;
                q_cap = CW'(1);
            end
        endcase
    end

endmodule

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
(
    input  logic [2:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic       div_access,
    output logic       we_txq,
    output logic       we_div_lo,
    output logic       we_div_hi,
    output logic       we_qctl,
    output logic       we_line,
    output logic       we_mctl,
    output logic       re_rxq
);

    always_comb begin
        we_txq    = 1'b0;
        we_div_lo = 1'b0;
        we_div_hi = 1'b0;
        we_qctl   = 1'b0;
        we_line   = 1'b0;
        we_mctl   = 1'b0;
        re_rxq    = rd && (addr == OFS_DATA) && !div_access;
        if (wr) begin
            unique case (addr)
                OFS_DATA: begin
                    we_txq    = !div_access;
                    we_div_lo = div_access;
                end
                OFS_DIVHI: we_div_hi = div_access;
                OFS_QCTL:  we_qctl   = 1'b1;
                OFS_LINE:  we_line   = 1'b1;
                OFS_MCTL:  we_mctl   = 1'b1;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int EXT_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    input  logic        bus_wr,
    output logic [7:0]  bus_rdata,
    output logic [15:0] divisor,
    output logic [5:0]  line_cfg,
    output logic        fifo_on,
    output logic        fifo_big,
    output logic        rts_out,
    input  logic        cts_in,
    input  logic        dsr_in,
    output logic [7:0]  tx_data,
    output logic        tx_ready,
    input  logic        tx_take,
    input  logic        tx_shift_busy,
    input  logic [7:0]  rx_data,
    input  logic        rx_put
);

    localparam int CW = $clog2(EXT_DEPTH) + 1;

    logic [7:0]    line_q;
    logic [7:0]    div_lo_q;
    logic [7:0]    div_hi_q;
    logic [7:0]    mctl_q;
    logic          div_access;
    logic          we_txq, we_div_lo, we_div_hi, we_qctl, we_line, we_mctl, re_rxq;
    logic          q_flush;
    logic [CW-1:0] q_cap;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]    rx_head;
    logic [7:0]    lstat;
    logic [7:0]    mstat;

    assign div_access = line_q[LINE_DIV_BIT];

    uart_rb_decode u_dec (
        .addr       (bus_addr),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .div_access (div_access),
        .we_txq     (we_txq),
        .we_div_lo  (we_div_lo),
        .we_div_hi  (we_div_hi),
        .we_qctl    (we_qctl),
        .we_line    (we_line),
        .we_mctl    (we_mctl),
        .re_rxq     (re_rxq)
    );

    uart_rb_qmode #(.EXT_DEPTH(EXT_DEPTH)) u_qmode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (we_qctl),
        .ctl_val (bus_wdata),
        .q_on    (fifo_on),
        .q_big   (fifo_big),
        .q_flush (q_flush),
        .q_cap   (q_cap)
    );

    uart_rb_fifo #(.DEPTH(EXT_DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (q_flush),
        .push  (we_txq),
        .pop   (tx_take),
        .din   (bus_wdata),
        .cap   (q_cap),
        .dout  (tx_data),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    uart_rb_fifo #(.DEPTH(EXT_DEPTH), .W(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (q_flush),
        .push  (rx_put),
        .pop   (re_rxq),
        .din   (rx_data),
        .cap   (q_cap),
        .dout  (rx_head),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= 8'h00;
            div_lo_q <= 8'h00;
            div_hi_q <= 8'h00;
            mctl_q   <= 8'h00;
        end else begin
            if (we_line)   line_q   <= bus_wdata;
            if (we_div_lo) div_lo_q <= bus_wdata;
            if (we_div_hi) div_hi_q <= bus_wdata;
            if (we_mctl)   mctl_q   <= bus_wdata;
        end
    end

    assign divisor  = {div_hi_q, div_lo_q};
    assign line_cfg = line_q[5:0];
    assign rts_out  = mctl_q[MCTL_RTS_BIT];
    assign tx_ready = !tx_empty;

    always_comb begin
        lstat    = 8'h00;
        lstat[0] = !rx_empty;
        lstat[5] = tx_empty;
        lstat[6] = tx_empty && !tx_shift_busy;
        mstat    = 8'h00;
        mstat[4] = cts_in;
        mstat[5] = dsr_in;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DATA:  bus_rdata = div_access ? div_lo_q : (rx_empty ? 8'h00 : rx_head);
            OFS_DIVHI: bus_rdata = div_access ? div_hi_q : 8'h00;
            OFS_LINE:  bus_rdata = line_q;
            OFS_MCTL:  bus_rdata = mctl_q;
            OFS_LSTAT: bus_rdata = lstat;
            OFS_MSTAT: bus_rdata = mstat;
            default:   bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int EXT_DEPTH = 64,
    localparam int CW       = $clog2(EXT_DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [15:0]   divisor,
    input logic          fifo_on,
    input logic          rts_out,
    input logic          tx_ready,
    input logic          tx_take,
    input logic          rx_put,
    input logic          dlab,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] cap
);

    a_r8_rts_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=> (rts_out == $past(bus_wdata[1])));

    a_r2_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && dlab && (bus_addr == 3'd0 || bus_addr == 3'd1)) |=> $stable(divisor));

    a_r4_tx_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= cap) && (rx_cnt <= cap));

    a_r5_flush_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2 && (fifo_on != bus_wdata[0])) |=> (tx_cnt == '0 && rx_cnt == '0));

    a_r7_tx_only_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(bus_wr));

    a_r12_take_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && tx_ready && !bus_wr) |=> (tx_cnt == $past(tx_cnt) - CW'(1)));

    a_r6_rx_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0 && !dlab && rx_cnt == CW'(1) && !rx_put) |=> (rx_cnt == '0));

endmodule

bind uart_regbank uart_regbank_chk #(.EXT_DEPTH(EXT_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .divisor   (divisor),
    .fifo_on   (fifo_on),
    .rts_out   (rts_out),
    .tx_ready  (tx_ready),
    .tx_take   (tx_take),
    .rx_put    (rx_put),
    .dlab      (line_q[7]),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .cap       (q_cap)
);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;

    localparam int CLK_PERIOD = 10;
    localparam int EXT        = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] divisor;
    logic [5:0]  line_cfg;
    logic        fifo_on, fifo_big, rts_out;
    logic        cts_in = 1'b0;
    logic        dsr_in = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic        tx_take = 1'b0;
    logic        tx_shift_busy = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_put = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    uart_regbank #(.EXT_DEPTH(EXT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .divisor(divisor),
        .line_cfg(line_cfg), .fifo_on(fifo_on), .fifo_big(fifo_big), .rts_out(rts_out),
        .cts_in(cts_in), .dsr_in(dsr_in), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_take(tx_take), .tx_shift_busy(tx_shift_busy), .rx_data(rx_data), .rx_put(rx_put)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic take(output logic [7:0] d, output logic r);
        @(negedge clk);
        tx_take = 1'b1;
        #1 d = tx_data; r = tx_ready;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic rx_push(logic [7:0] d);
        @(negedge clk);
        rx_data = d; rx_put = 1'b1;
        @(negedge clk);
        rx_put = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(3'd3, v); chk("R1", "line reset", v, 8'h00);
        bus_read(3'd4, v); chk("R1", "mctl reset", v, 8'h00);
        bus_read(3'd5, v); chk("R1", "lstat reset", v, 8'h60);
        chk("R1", "divisor reset", divisor, 16'h0000);
        chk("R1", "rts/fifo reset", {rts_out, fifo_on, fifo_big}, 3'b000);
        bus_read(3'd0, v); chk("R6", "empty rx read", v, 8'h00);
    endtask

    task automatic t_divisor();
        logic [7:0] v;
        bus_write(3'd3, 8'h80);
        bus_write(3'd0, 8'h34);
        bus_write(3'd1, 8'h12);
        chk("R2", "divisor out", divisor, 16'h1234);
        chk("R2", "no tx push", tx_ready, 1'b0);
        bus_read(3'd0, v); chk("R2", "div low read", v, 8'h34);
        bus_read(3'd1, v); chk("R2", "div high read", v, 8'h12);
        bus_write(3'd3, 8'h5B);
        bus_read(3'd3, v); chk("R3", "line readback", v, 8'h5B);
        chk("R3", "line_cfg", line_cfg, 6'h1B);
        bus_read(3'd1, v); chk("R10", "ofs1 no access bit", v, 8'h00);
        chk("R2", "divisor kept", divisor, 16'h1234);
    endtask

    task automatic t_modem();
        logic [7:0] v;
        bus_write(3'd4, 8'h02);
        chk("R8", "rts high", rts_out, 1'b1);
        bus_read(3'd4, v); chk("R8", "mctl readback", v, 8'h02);
        bus_write(3'd4, 8'h01);
        chk("R8", "rts low", rts_out, 1'b0);
        @(negedge clk); cts_in = 1'b1; dsr_in = 1'b0;
        bus_read(3'd6, v); chk("R9", "cts only", v, 8'h10);
        @(negedge clk); dsr_in = 1'b1;
        bus_read(3'd6, v); chk("R9", "cts dsr", v, 8'h30);
        @(negedge clk); cts_in = 1'b0;
        bus_read(3'd6, v); chk("R9", "dsr only", v, 8'h20);
        bus_write(3'd6, 8'hFF);
        bus_write(3'd5, 8'hFF);
        bus_write(3'd7, 8'h55);
        bus_read(3'd6, v); chk("R10", "mstat write ignored", v, 8'h20);
        bus_read(3'd5, v); chk("R10", "lstat write ignored", v, 8'h60);
        bus_read(3'd7, v); chk("R10", "ofs7 reads zero", v, 8'h00);
        bus_read(3'd2, v); chk("R10", "ofs2 reads zero", v, 8'h00);
        chk("R10", "other regs untouched", {divisor, rts_out}, {16'h1234, 1'b0});
    endtask

    task automatic t_single();
        logic [7:0] d; logic r; logic [7:0] v;
        bus_write(3'd0, 8'hA1);
        bus_write(3'd0, 8'hA2);
        chk("R12", "tx_ready", tx_ready, 1'b1);
        bus_read(3'd5, v); chk("R7", "lstat non-empty", v, 8'h00);
        take(d, r); chk("R4", "cap1 head", d, 8'hA1);
        chk("R4", "cap1 second dropped", tx_ready, 1'b0);
        @(negedge clk); tx_shift_busy = 1'b1;
        bus_read(3'd5, v); chk("R7", "empty but shifting", v, 8'h20);
        @(negedge clk); tx_shift_busy = 1'b0;
        bus_read(3'd5, v); chk("R7", "fully idle", v, 8'h60);
        rx_push(8'h11);
        rx_push(8'h22);
        bus_read(3'd0, v); chk("R11", "rx kept first", v, 8'h11);
        bus_read(3'd5, v); chk("R11", "rx second dropped", v[0], 1'b0);
    endtask

    task automatic t_std();
        logic [7:0] d; logic r; int bad = 0;
        bus_write(3'd2, 8'h01);
        chk("R4", "std mode flags", {fifo_on, fifo_big}, 2'b10);
        for (int i = 0; i < 17; i++) bus_write(3'd0, 8'h40 + 8'(i));
        for (int i = 0; i < 16; i++) begin
            take(d, r);
            if (d !== 8'h40 + 8'(i) || r !== 1'b1) bad++;
        end
        chk("R12", "std order", bad, 0);
        chk("R4", "std 17th dropped", tx_ready, 1'b0);
    endtask

    task automatic t_ext();
        logic [7:0] d; logic r; int n = 0; int bad = 0;
        bus_write(3'd2, 8'h21);
        chk("R4", "ext mode flags", {fifo_on, fifo_big}, 2'b11);
        for (int i = 0; i < EXT + 1; i++) bus_write(3'd0, 8'(i));
        while (tx_ready && n < EXT + 8) begin
            take(d, r);
            if (d !== 8'(n)) bad++;
            n++;
        end
        chk("R4", "ext capacity", n, EXT);
        chk("R4", "ext contents intact", bad, 0);
    endtask

    task automatic t_flush();
        logic [7:0] v;
        bus_write(3'd0, 8'hC0);
        bus_write(3'd0, 8'hC1);
        rx_push(8'h99);
        bus_write(3'd2, 8'h21);
        chk("R5", "same mode keeps tx", {tx_ready, tx_data}, {1'b1, 8'hC0});
        bus_read(3'd5, v); chk("R5", "same mode keeps rx", v[0], 1'b1);
        bus_write(3'd2, 8'h01);
        chk("R5", "mode change empties tx", tx_ready, 1'b0);
        bus_read(3'd5, v); chk("R5", "mode change empties rx", v[0], 1'b0);
        bus_write(3'd2, 8'h00);
        chk("R5", "queues off", {fifo_on, fifo_big}, 2'b00);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        bus_write(3'd2, 8'h01);
        rx_push(8'hA0); rx_push(8'hA1); rx_push(8'hA2);
        bus_read(3'd5, v); chk("R6", "rx ready", v, 8'h61);
        bus_read(3'd0, v); chk("R6", "rx first", v, 8'hA0);
        bus_read(3'd0, v); chk("R6", "rx second", v, 8'hA1);
        bus_read(3'd5, v); chk("R6", "still ready", v[0], 1'b1);
        bus_read(3'd0, v); chk("R6", "rx third", v, 8'hA2);
        bus_read(3'd5, v); chk("R6", "ready cleared", v[0], 1'b0);
    endtask

    task automatic t_isolation();
        logic [7:0] v;
        rx_push(8'h5A);
        bus_write(3'd3, 8'h83);
        bus_read(3'd0, v); chk("R2", "div low not rx", v, 8'h34);
        bus_write(3'd0, 8'h77);
        chk("R2", "divisor updated", divisor, 16'h1277);
        chk("R2", "no tx push", tx_ready, 1'b0);
        bus_write(3'd3, 8'h03);
        bus_read(3'd5, v); chk("R2", "rx not popped", v[0], 1'b1);
        bus_read(3'd0, v); chk("R2", "rx byte intact", v, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divisor();
        t_modem();
        t_single();
        t_std();
        t_ext();
        t_flush();
        t_rx();
        t_isolation();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule